// File: doc/BRIEF.md
# Cache Diagnostic and Exception Vector Status Register

This block is a processor status/control register that collects the cache diagnostic controls, two sticky status flags, a cache-miss flag and the bootstrap-vector selector. Software reads and writes it through a simple port: a write strobe with a data word, and a read word that always shows the current state. Hardware event inputs log cache parity errors, record the outcome of data loads made while the cache is isolated, and latch a shutdown when a translation lookup matches more than one TLB entry.

The outputs drive the cache isolate and parity-zero controls and a translation-inhibit line to the TLB. They also provide the two exception vector addresses. Those addresses move into the boot ROM region while the bootstrap-vector bit is set. The parity-error flag is cleared by writing one to it. The shutdown flag cannot be written and is cleared only by reset.

Top module: `cache_tlb_status`

## Requirements
- R1: After reset the read word is 0x00000020: isolate (bit 0), parity-zero (bit 1), cache-miss (bit 2), parity-error (bit 3) and TLB-shutdown (bit 4) are 0, and bootstrap-vector (bit 5) is 1. All other read bits are always 0.
- R2: A write (wrEn high) loads isolate, parity-zero and bootstrap-vector from write data bits 0, 1 and 5. The new values show on the read word and on isoOut, parZeroOut and bootVecOut from the next cycle.
- R3: A parityErrEvt pulse sets the parity-error bit (bit 3) on the next cycle.
- R4: A write with data bit 3 at 1 clears the parity-error bit. A write with data bit 3 at 0 leaves it unchanged.
- R5: When parityErrEvt and a clearing write occur in the same cycle, the parity-error bit stays 1.
- R6: A multiMatchEvt pulse sets the TLB-shutdown bit (bit 4). Writes have no effect on it, and it stays set until reset.
- R7: xlateInhibit is high in every cycle that the TLB-shutdown bit is set.
- R8: With bootstrap-vector at 1, refillVec is 0xbfc00100 and generalVec is 0xbfc00180. With it at 0, they are 0x80000000 and 0x80000080.
- R9: The cache-miss bit (bit 2) takes the value of loadMiss only in a cycle where loadValid is high and isolate is set. In all other cycles it holds its value, and writes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Current register contents |
| parityErrEvt | input | 1 | Cache parity error detected |
| loadValid | input | 1 | A data load completed this cycle |
| loadMiss | input | 1 | The completing data load missed in the cache |
| multiMatchEvt | input | 1 | Lookup hit several TLB entries at once |
| isoOut | output | 1 | Cache isolate control |
| parZeroOut | output | 1 | Force outgoing parity bits to zero |
| bootVecOut | output | 1 | Bootstrap vector selector |
| xlateInhibit | output | 1 | Blocks translations and probes |
| refillVec | output | 32 | TLB refill exception vector |
| generalVec | output | 32 | General exception vector |

## Verification
The assertions assume that the event inputs are single-cycle pulses that are sampled only out of reset. They also assume that loadMiss is meaningful only when loadValid is high. The stimulus drives every input on the falling clock edge. Each event is held high for exactly one cycle and then released. Every input is kept at 0 during reset, so no event overlaps the reset release. The collision case is produced on purpose as one cycle that carries both a parity event and a clearing write.

// File: rtl/cache_tlb_status_pkg.sv
package cache_tlb_status_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 32;
  localparam int ISO_BIT  = 0;
  localparam int PZ_BIT   = 1;
  localparam int MISS_BIT = 2;
  localparam int PERR_BIT = 3;
  localparam int SHUT_BIT = 4;
  localparam int BOOT_BIT = 5;

  typedef struct packed {
    logic loadCtl;
    logic setPerr;
    logic clrPerr;
    logic setShut;
    logic loadMiss;
    logic missVal;
  } ctlStrobes_t;
endpackage

// File: rtl/cache_tlb_status_ctl.sv
module cache_tlb_status_ctl
  import cache_tlb_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               parityErrEvt,
  input  logic               loadValid,
  input  logic               loadMiss,
  input  logic               multiMatchEvt,
  input  logic               isoNow,
  output ctlStrobes_t        strb
);
  always_comb begin
    strb          = '0;
    strb.loadCtl  = wrEn;
    strb.setPerr  = parityErrEvt;
    // set wins over a simultaneous write-one clear (R5)
    strb.clrPerr  = wrEn && wrData[PERR_BIT] && !parityErrEvt;
    strb.setShut  = multiMatchEvt;
    strb.loadMiss = loadValid && isoNow;
    strb.missVal  = loadMiss;
  end

  // R5: clear and set strobes never coexist
  p_no_clr_on_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clrPerr && strb.setPerr));
endmodule

// File: rtl/cache_tlb_status_dp.sv
module cache_tlb_status_dp
  import cache_tlb_status_pkg::*;
#(
  parameter logic [ADDR_W-1:0] NORM_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hbfc0_0100,
  parameter logic [ADDR_W-1:0] GEN_OFS   = 32'h0000_0080
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  wrData,
  input  ctlStrobes_t        strb,
  output logic [DATA_W-1:0]  rdData,
  output logic               isoQ,
  output logic               pzQ,
  output logic               bootQ,
  output logic               shutQ,
  output logic [ADDR_W-1:0]  refillVec,
  output logic [ADDR_W-1:0]  generalVec
);
  logic missQ, perrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isoQ  <= 1'b0;
      pzQ   <= 1'b0;
      bootQ <= 1'b1;
      missQ <= 1'b0;
      perrQ <= 1'b0;
      shutQ <= 1'b0;
    end else begin
      if (strb.loadCtl) begin
        isoQ  <= wrData[ISO_BIT];
        pzQ   <= wrData[PZ_BIT];
        bootQ <= wrData[BOOT_BIT];
      end
      if (strb.setPerr)      perrQ <= 1'b1;
      else if (strb.clrPerr) perrQ <= 1'b0;
      if (strb.setShut)      shutQ <= 1'b1;
      if (strb.loadMiss)     missQ <= strb.missVal;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[ISO_BIT]  = isoQ;
    rdData[PZ_BIT]   = pzQ;
    rdData[MISS_BIT] = missQ;
    rdData[PERR_BIT] = perrQ;
    rdData[SHUT_BIT] = shutQ;
    rdData[BOOT_BIT] = bootQ;
  end

  localparam logic [ADDR_W-1:0] NORM_GEN = NORM_BASE + GEN_OFS;
  localparam logic [ADDR_W-1:0] BOOT_GEN = BOOT_BASE + GEN_OFS;

  assign refillVec  = bootQ ? BOOT_BASE : NORM_BASE;
  assign generalVec = bootQ ? BOOT_GEN  : NORM_GEN;

  p_perr_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setPerr |=> perrQ);
  p_perr_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrPerr |=> !perrQ);
  p_perr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setPerr && !strb.clrPerr) |=> $stable(perrQ));
  p_shut_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    shutQ |=> shutQ);
  p_miss_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadMiss |=> $stable(missQ));
endmodule

// File: rtl/cache_tlb_status.sv
module cache_tlb_status
  import cache_tlb_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               parityErrEvt,
  input  logic               loadValid,
  input  logic               loadMiss,
  input  logic               multiMatchEvt,
  output logic               isoOut,
  output logic               parZeroOut,
  output logic               bootVecOut,
  output logic               xlateInhibit,
  output logic [ADDR_W-1:0]  refillVec,
  output logic [ADDR_W-1:0]  generalVec
);
  ctlStrobes_t strb;
  logic shutQ;

  cache_tlb_status_ctl ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .parityErrEvt(parityErrEvt), .loadValid(loadValid), .loadMiss(loadMiss),
    .multiMatchEvt(multiMatchEvt), .isoNow(isoOut), .strb(strb)
  );

  cache_tlb_status_dp dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb), .rdData(rdData),
    .isoQ(isoOut), .pzQ(parZeroOut), .bootQ(bootVecOut), .shutQ(shutQ),
    .refillVec(refillVec), .generalVec(generalVec)
  );

  assign xlateInhibit = shutQ;

  p_inhibit_after_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    multiMatchEvt |=> xlateInhibit);
  p_boot_vec_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BOOT_BIT] |-> (refillVec == 32'hbfc0_0100 && generalVec == 32'hbfc0_0180));
  p_norm_vec_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[BOOT_BIT] |-> (refillVec == 32'h8000_0000 && generalVec == 32'h8000_0080));
  p_write_ctl_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (isoOut == $past(wrData[ISO_BIT]) && bootVecOut == $past(wrData[BOOT_BIT])));
endmodule

// File: tb/cache_tlb_status_tb_top.sv
module cache_tlb_status_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic parityErrEvt = 1'b0, loadValid = 1'b0, loadMiss = 1'b0, multiMatchEvt = 1'b0;
  logic [31:0] rdData, refillVec, generalVec;
  logic isoOut, parZeroOut, bootVecOut, xlateInhibit;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cache_tlb_status dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .parityErrEvt(parityErrEvt), .loadValid(loadValid), .loadMiss(loadMiss),
    .multiMatchEvt(multiMatchEvt), .isoOut(isoOut), .parZeroOut(parZeroOut),
    .bootVecOut(bootVecOut), .xlateInhibit(xlateInhibit),
    .refillVec(refillVec), .generalVec(generalVec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one cycle: inputs already set at negedge, advance to next negedge, clear pulses
  task automatic tick();
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; parityErrEvt = 1'b0;
    loadValid = 1'b0; loadMiss = 1'b0; multiMatchEvt = 1'b0;
  endtask

  task automatic regWrite(input logic [31:0] d);
    wrEn = 1'b1; wrData = d; tick();
  endtask

  task automatic doReset();
    rstN = 1'b0; tick(); tick(); rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 reset word", rdData, 32'h20);
    chk("R1 inhibit", {31'b0, xlateInhibit}, 32'h0);
    chk("R8 boot refill", refillVec, 32'hbfc0_0100);
    chk("R8 boot general", generalVec, 32'hbfc0_0180);
  endtask

  task automatic testCtlWrite();
    regWrite(32'hffff_ffc3);
    chk("R2 write iso/pz, boot cleared", rdData, 32'h3);
    chk("R2 outputs", {29'b0, bootVecOut, parZeroOut, isoOut}, 32'h3);
    chk("R8 normal refill", refillVec, 32'h8000_0000);
    chk("R8 normal general", generalVec, 32'h8000_0080);
    regWrite(32'h20);
    chk("R2 boot restored", rdData, 32'h20);
    chk("R8 boot refill again", refillVec, 32'hbfc0_0100);
  endtask

  task automatic testParity();
    parityErrEvt = 1'b1; tick();
    chk("R3 parity set", rdData & 32'h8, 32'h8);
    regWrite(32'h20);
    chk("R4 write zero keeps", rdData & 32'h8, 32'h8);
    wrEn = 1'b1; wrData = 32'h28; parityErrEvt = 1'b1; tick();
    chk("R5 set beats clear", rdData & 32'h8, 32'h8);
    regWrite(32'h28);
    chk("R4 write one clears", rdData & 32'h8, 32'h0);
  endtask

  task automatic testShutdown();
    chk("R7 inhibit low before", {31'b0, xlateInhibit}, 32'h0);
    regWrite(32'h30);
    chk("R6 write cannot set", rdData & 32'h10, 32'h0);
    multiMatchEvt = 1'b1; tick();
    chk("R6 shutdown set", rdData & 32'h10, 32'h10);
    chk("R7 inhibit high", {31'b0, xlateInhibit}, 32'h1);
    regWrite(32'h20);
    tick(); tick();
    chk("R6 sticky after write", rdData & 32'h10, 32'h10);
    chk("R7 inhibit still high", {31'b0, xlateInhibit}, 32'h1);
    doReset();
    chk("R6 cleared by reset", rdData & 32'h10, 32'h0);
  endtask

  task automatic testMiss();
    loadValid = 1'b1; loadMiss = 1'b1; tick();
    chk("R9 no update when not isolated", rdData & 32'h4, 32'h0);
    regWrite(32'h21);
    loadValid = 1'b1; loadMiss = 1'b1; tick();
    chk("R9 miss captured", rdData & 32'h4, 32'h4);
    loadMiss = 1'b1; tick();
    chk("R9 holds without load", rdData & 32'h4, 32'h4);
    regWrite(32'h21);
    chk("R9 write ignored", rdData & 32'h4, 32'h4);
    loadValid = 1'b1; loadMiss = 1'b0; tick();
    chk("R9 hit captured", rdData & 32'h4, 32'h0);
    regWrite(32'h24);
    chk("R9 write one ignored", rdData & 32'h4, 32'h0);
    loadValid = 1'b1; loadMiss = 1'b1; tick();
    chk("R9 no update after deisolate", rdData & 32'h4, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testCtlWrite();
    testParity();
    testShutdown();
    testMiss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule